// File: doc/BRIEF.md
# Two-Timer Motor PWM Generator

This block produces six pulse-width-modulated outputs for driving a small motor bridge. Two period timers run independently. Each has its own prescaler and its own 16-bit period. Channels 0 to 2 follow the first timer and channels 3 to 5 follow the second. Either timer counts in one of two ways: a sawtooth that runs up and wraps, or a triangle that runs up and then back down. Each channel compares the count of its timer against its own compare value. The output is high while the count is below that value. In the triangle mode this places the two switching points symmetrically about the top of the count.

Software programs the block through a simple write-only register port. Period, prescale, count mode and compare values are held in shadow registers. They reach the counting logic only when a new period begins, so an update never produces a truncated pulse. The one exception is a stopped timer, which picks up new values at once. A pairing control turns each odd channel into the complement of the even channel below it, which gives the high and low switch signals of one bridge leg.

Top module: `mcpwm_top`

## Requirements
- R1: Channels 0, 1 and 2 follow timer 0 and channels 3, 4 and 5 follow timer 1. The two timers run concurrently with separate settings and do not affect each other.
- R2: A write with `wr_en` high is stored on the clock edge. Register addresses: 0 is period 0, 1 is period 1, 2 is prescale 0, 3 is prescale 1, 4 is control, and 8+i is the compare value of channel i. Control bits: bit 0 enables timer 0, bit 1 enables timer 1, bit 2 selects triangle mode for timer 0, bit 3 selects triangle mode for timer 1, and bits 4, 5 and 6 pair channels 0/1, 2/3 and 4/5.
- R3: Sawtooth mode with period P counts 0, 1, …, P and then returns to 0, so one period lasts P+1 counts. A channel with compare C≤P is high for C of those counts.
- R4: Triangle mode with period P≥1 counts 0 up to P and then down through 1, so one period lasts 2P counts. A channel with compare 1≤C≤P is high for 2C−1 of those counts.
- R5: With prescale D, the counter advances once every D+1 clock cycles, which stretches every period and pulse by a factor of D+1.
- R6: A compare value of 0 holds a channel low. A compare value greater than the period holds it high.
- R7: While a timer runs, new period, prescale, mode and compare values take effect only at the start of its next period. While a timer is stopped, they take effect immediately.
- R8: When a pair bit is set, the odd channel of that pair outputs the inverse of the even channel on every cycle.
- R9: A disabled timer holds its count at 0 and drives the unpaired outputs of its channels low.
- R10: After reset, all registers read as zero and all six outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_o | output | 6 | PWM outputs, bit i is channel i |

## Verification
Duty is measured by counting high samples over a window that covers a whole number of periods. A sawtooth at prescale 0 and a sawtooth at prescale 1 are compared, and the two counts differ only by the stretch factor. A triangle on timer 0 runs at the same time as a sawtooth on timer 1, which separates the two count shapes and shows that the timers are independent. Compare values of zero and above the period cover the saturated cases. A compare value rewritten in the middle of a long period shows whether the shadow is honoured or bypassed. Pairing is checked sample by sample, and stopping a timer shows the idle levels.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

   // count direction of a period timer
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } cnt_dir_e;

   // register offsets derived from the timer count
   function automatic int per_addr(input int t);
      return t;
   endfunction

   function automatic int pre_addr(input int n_tmr, input int t);
      return n_tmr + t;
   endfunction

   function automatic int ctl_addr(input int n_tmr);
      return 2 * n_tmr;
   endfunction

endpackage

// File: rtl/mcpwm_regs.sv
module mcpwm_regs
   import mcpwm_pkg::*;
#(
   parameter int N_TMR    = 2,
   parameter int N_CH     = 6,
   parameter int CNT_W    = 16,
   parameter int PRE_W    = 8,
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int CMP_BASE = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [N_TMR-1:0][CNT_W-1:0]  per_sh,
   output logic [N_TMR-1:0][PRE_W-1:0]  pre_sh,
   output logic [N_TMR-1:0]             tmr_en,
   output logic [N_TMR-1:0]             ctr_sh,
   output logic [N_CH/2-1:0]            pair_en,
   output logic [N_CH-1:0][CNT_W-1:0]   cmp_sh
);
   localparam int N_PAIR  = N_CH / 2;
   localparam int CTL_A   = ctl_addr(N_TMR);
   localparam int PAIR_LO = 2 * N_TMR;

   logic ctl_hit;
   assign ctl_hit = wr_en && (wr_addr == ADDR_W'(CTL_A));

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_sh[t] <= '0;
            pre_sh[t] <= '0;
            tmr_en[t] <= 1'b0;
            ctr_sh[t] <= 1'b0;
         end else begin
            if (wr_en && wr_addr == ADDR_W'(per_addr(t)))
               per_sh[t] <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == ADDR_W'(pre_addr(N_TMR, t)))
               pre_sh[t] <= wr_data[PRE_W-1:0];
            if (ctl_hit) begin
               tmr_en[t] <= wr_data[t];
               ctr_sh[t] <= wr_data[N_TMR + t];
            end
         end
      end
   end

   for (genvar k = 0; k < N_PAIR; k++) begin : g_pair_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pair_en[k] <= 1'b0;
         else if (ctl_hit) pair_en[k] <= wr_data[PAIR_LO + k];
      end
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_cmp_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_sh[c] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(CMP_BASE + c))
            cmp_sh[c] <= wr_data[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/mcpwm_timer.sv
module mcpwm_timer
   import mcpwm_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] per_sh,
   input  logic [PRE_W-1:0] pre_sh,
   input  logic             ctr_sh,
   output logic [CNT_W-1:0] cnt,
   output logic             load
);
   logic [CNT_W-1:0] per_act;
   logic [PRE_W-1:0] pre_act, pre_cnt;
   logic             ctr_act;
   cnt_dir_e         dir;
   logic             tick, wrap;

   assign tick = (pre_cnt == pre_act);

   // sawtooth wraps at the top; triangle wraps when leaving the bottom
   always_comb begin
      if (ctr_act)
         wrap = (dir == DIR_DOWN || cnt >= per_act) && (cnt <= CNT_W'(1));
      else
         wrap = (cnt >= per_act);
   end

   assign load = !en || (tick && wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         dir     <= DIR_UP;
         pre_cnt <= '0;
         per_act <= '0;
         pre_act <= '0;
         ctr_act <= 1'b0;
      end else if (!en) begin
         cnt     <= '0;
         dir     <= DIR_UP;
         pre_cnt <= '0;
         per_act <= per_sh;
         pre_act <= pre_sh;
         ctr_act <= ctr_sh;
      end else if (tick) begin
         pre_cnt <= '0;
         if (wrap) begin
            cnt     <= '0;
            dir     <= DIR_UP;
            per_act <= per_sh;
            pre_act <= pre_sh;
            ctr_act <= ctr_sh;
         end else if (!ctr_act) begin
            cnt <= cnt + CNT_W'(1);
         end else if (dir == DIR_UP) begin
            if (cnt >= per_act) begin
               cnt <= cnt - CNT_W'(1);
               dir <= DIR_DOWN;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end else begin
         pre_cnt <= pre_cnt + PRE_W'(1);
      end
   end

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> cnt <= per_act);

   // R3
   edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ctr_act && tick && cnt < per_act) |=> cnt == $past(cnt) + CNT_W'(1));

   // R5
   presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(cnt));

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt == '0);

endmodule

// File: rtl/mcpwm_chan.sv
module mcpwm_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_sh,
   output logic             raw
);
   logic [CNT_W-1:0] cmp_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cmp_act <= '0;
      else if (load) cmp_act <= cmp_sh;
   end

   assign raw = en && (cnt < cmp_act);

   // R7
   cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cmp_act));

endmodule

// File: rtl/mcpwm_top.sv
module mcpwm_top #(
   parameter int N_TMR    = 2,
   parameter int N_CH     = 6,
   parameter int CNT_W    = 16,
   parameter int PRE_W    = 8,
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int CMP_BASE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [N_CH-1:0]   pwm_o
);
   localparam int N_PAIR     = N_CH / 2;
   localparam int CH_PER_TMR = N_CH / N_TMR;

   if (N_CH % N_TMR != 0) begin : g_bad_split
      $error("N_CH must be a multiple of N_TMR");
   end
   if (N_CH % 2 != 0) begin : g_bad_pair
      $error("N_CH must be even for pairing");
   end
   if (DATA_W < CNT_W || DATA_W < PRE_W || DATA_W < 2 * N_TMR + N_PAIR) begin : g_bad_data
      $error("DATA_W too narrow for the register fields");
   end
   if (2 * N_TMR >= CMP_BASE || CMP_BASE + N_CH > 2 ** ADDR_W) begin : g_bad_map
      $error("register map does not fit the address space");
   end

   logic [N_TMR-1:0][CNT_W-1:0] per_sh;
   logic [N_TMR-1:0][PRE_W-1:0] pre_sh;
   logic [N_TMR-1:0]            tmr_en, ctr_sh, tmr_load;
   logic [N_TMR-1:0][CNT_W-1:0] tmr_cnt;
   logic [N_PAIR-1:0]           pair_en;
   logic [N_CH-1:0][CNT_W-1:0]  cmp_sh;
   logic [N_CH-1:0]             raw;

   mcpwm_regs #(
      .N_TMR(N_TMR), .N_CH(N_CH), .CNT_W(CNT_W), .PRE_W(PRE_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_BASE(CMP_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .per_sh(per_sh), .pre_sh(pre_sh),
      .tmr_en(tmr_en), .ctr_sh(ctr_sh), .pair_en(pair_en), .cmp_sh(cmp_sh)
   );

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      mcpwm_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tmr (
         .clk(clk), .rst_n(rst_n), .en(tmr_en[t]),
         .per_sh(per_sh[t]), .pre_sh(pre_sh[t]), .ctr_sh(ctr_sh[t]),
         .cnt(tmr_cnt[t]), .load(tmr_load[t])
      );
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      localparam int TI = c / CH_PER_TMR;
      mcpwm_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .en(tmr_en[TI]), .load(tmr_load[TI]),
         .cnt(tmr_cnt[TI]), .cmp_sh(cmp_sh[c]), .raw(raw[c])
      );
   end

   for (genvar k = 0; k < N_PAIR; k++) begin : g_pair_out
      assign pwm_o[2*k]   = raw[2*k];
      assign pwm_o[2*k+1] = pair_en[k] ? !raw[2*k] : raw[2*k+1];
   end

endmodule

// File: tb/tb_mcpwm_top.sv
module tb_mcpwm_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [5:0]  pwm_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   mcpwm_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm_o)
   );

   always #10 clk = ~clk;

   // control bit encodings per R2
   localparam logic [15:0] EN0 = 16'h0001, EN1 = 16'h0002,
                           CTR0 = 16'h0004, PAIR01 = 16'h0010;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic count_high(input int ch, input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_o[ch]) hi++;
      end
   endtask

   task automatic wait_rise(input int ch);
      logic prev;
      @(negedge clk);
      prev = pwm_o[ch];
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (!prev && pwm_o[ch]) break;
         prev = pwm_o[ch];
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(pwm_o == 6'b0, "R10 reset outputs", pwm_o, 0);
      wr(4'd8, 16'd5);
      repeat (3) @(negedge clk);
      check(pwm_o[0] == 1'b0, "R9 stopped timer low", pwm_o[0], 0);
   endtask

   task automatic t_edge();
      int hi;
      wr(4'd0, 16'd9);
      wr(4'd8, 16'd3);
      wr(4'd9, 16'd0);
      wr(4'd10, 16'd12);
      wr(4'd4, EN0);
      count_high(0, 100, hi);
      check(hi == 30, "R3 sawtooth duty", hi, 30);
      count_high(1, 100, hi);
      check(hi == 0, "R6 compare zero", hi, 0);
      count_high(2, 100, hi);
      check(hi == 100, "R6 compare above period", hi, 100);
   endtask

   task automatic t_presc();
      int hi;
      wr(4'd4, 16'd0);
      wr(4'd2, 16'd1);
      wr(4'd4, EN0);
      count_high(0, 200, hi);
      check(hi == 60, "R5 prescale by two", hi, 60);
      wr(4'd4, 16'd0);
      wr(4'd2, 16'd0);
   endtask

   task automatic t_centre_indep();
      int hi0, hi3;
      wr(4'd0, 16'd8);
      wr(4'd1, 16'd4);
      wr(4'd11, 16'd2);
      wr(4'd4, EN0 | EN1 | CTR0);
      hi0 = 0; hi3 = 0;
      for (int i = 0; i < 160; i++) begin
         @(negedge clk);
         if (pwm_o[0]) hi0++;
         if (pwm_o[3]) hi3++;
      end
      check(hi0 == 50, "R4 triangle duty", hi0, 50);
      check(hi3 == 64, "R1 timer1 independent", hi3, 64);
   endtask

   task automatic t_pair();
      int bad, hi;
      wr(4'd4, EN0 | EN1 | CTR0 | PAIR01);
      bad = 0; hi = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (pwm_o[1] == pwm_o[0]) bad++;
         if (pwm_o[0]) hi++;
      end
      check(bad == 0, "R8 pair complement", bad, 0);
      check(hi == 20, "R8 leader unchanged", hi, 20);
   endtask

   task automatic t_disable();
      wr(4'd4, PAIR01);
      @(negedge clk);
      check(pwm_o[0] == 1'b0, "R9 disabled low", pwm_o[0], 0);
      check(pwm_o[1] == 1'b1, "R9 paired partner high", pwm_o[1], 1);
      check(pwm_o[3] == 1'b0, "R9 timer1 disabled low", pwm_o[3], 0);
   endtask

   task automatic t_buffer();
      int hi;
      wr(4'd4, 16'd0);
      wr(4'd0, 16'd99);
      wr(4'd8, 16'd50);
      wr(4'd4, EN0);
      wait_rise(0);
      repeat (10) @(negedge clk);
      wr(4'd8, 16'd5);
      count_high(0, 30, hi);
      check(hi == 30, "R7 compare held until period end", hi, 30);
      wait_rise(0);
      count_high(0, 99, hi);
      hi = hi + 1;
      check(hi == 5, "R7 compare applied next period", hi, 5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_edge();
      t_presc();
      t_centre_indep();
      t_pair();
      t_disable();
      t_buffer();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule